// File: doc/BRIEF.md
# Lowest-Priority Serial Interrupt Message Sender

This block is the sending end of a two-wire interrupt message bus. Each bus cycle carries one pair of bits. On request it sends a lowest-priority interrupt message that has no focus processor. The frame holds:

- the message type
- a 4-bit arbitration ID
- destination mode and a 3-bit delivery mode
- level and trigger mode
- an 8-bit vector and an 8-bit destination
- a checksum and a postamble

After the postamble the block lets go of both lines. The receivers then use the status, priority arbitration and tie-break cycles. In the final status cycle the block samples the bus. If no receiver was left after arbitration, the block sends the whole message again. A parameter sets the maximum number of resends.

One bus cycle takes one clock. The bus is wired-AND, so a released line reads 1. `bus_o` is the value this block drives onto the bus, and `bus_i` is the value seen on the bus. A bit pair is written `{bus[1], bus[0]}`. An attempt lasts 34 cycles, numbered 1 to 34.

Top module: `irq_lp_msg_tx`

## Requirements
- R1: After reset, and whenever no message is in progress, `bus_o` is 11, `done_o` and `error_o` are 0, and `retry_cnt_o` holds its last value (0 after reset).
- R2: If `req_i` is high at a clock edge while the block is idle, the message is accepted, and frame cycle 1 starts in the next clock. Each attempt then advances one frame cycle per clock through cycle 34.
- R3: Frame cycle 1 carries the message type: 01 when `eoi_i` is 0 (normal interrupt) and 11 when `eoi_i` is 1 (end of interrupt).
- R4: Frame cycles 2 to 5 carry arbitration ID bits 3, 2, 1 and 0, in that order, on `bus_o[1]`, with `bus_o[0]` at 0.
- R5: Frame cycles 6 to 16 carry these pairs in order: {dest mode, dlv[2]}, {dlv[1], dlv[0]}, {level, trig}, then vector bits 7..0 as four pairs, high bit first, then destination bits 7..0 the same way.
- R6: Frame cycle 17 carries the sum modulo 4 of the eleven pairs in cycles 6 to 16. Each pair is read as the number 2*bit1 + bit0.
- R7: Frame cycle 18 is 00. In cycles 19 to 34 the block releases the bus (`bus_o` = 11).
- R8: `bus_i` is sampled at the clock edge that ends cycle 33. If it reads 10, `done_o` is high for exactly the one clock after cycle 34, and `error_o` stays low.
- R9: Any other value sampled in cycle 33 (00, 01, 11) causes a resend if resends remain. The new attempt starts at cycle 1 in the clock right after cycle 34, and `retry_cnt_o` rises by one at that point.
- R10: If the attempt made after `MAX_RETRY` resends also fails, `done_o` and `error_o` pulse together for one clock. `retry_cnt_o` then stays at `MAX_RETRY` until the next message is accepted.
- R11: A `req_i` that arrives while a message is in progress is ignored. Field inputs are captured when a message is accepted, and later changes to them do not affect the frame or its resends.
- R12: A new message can be accepted in the same clock that `done_o` is high. `retry_cnt_o` clears to 0 when a message is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one bus cycle per clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Send request |
| eoi_i | input | 1 | Message type: 1 = end of interrupt |
| arb_id_i | input | 4 | Arbitration ID of the sender |
| dst_mode_i | input | 1 | Destination mode |
| dlv_mode_i | input | 3 | Delivery mode |
| level_i | input | 1 | Level |
| trig_i | input | 1 | Trigger mode |
| vector_i | input | 8 | Interrupt vector |
| dest_i | input | 8 | Destination |
| bus_i | input | 2 | Resolved bus value seen on the wires |
| bus_o | output | 2 | Value driven onto the bus (11 = released) |
| done_o | output | 1 | One-clock pulse when the message finishes |
| error_o | output | 1 | Pulses with `done_o` when resends ran out |
| retry_cnt_o | output | RETRY_W | Number of resends made for the current message |

## Verification
Two events can land in the same clock. The completion pulse of one message and the acceptance of the next both fall in the idle clock that follows cycle 34. The bench provokes this by raising the next request in that clock, every time. It then expects the next clock to show cycle 1 of the new frame with `done_o` low and `retry_cnt_o` cleared. A second collision happens at cycle 34 itself, where the block must choose between finishing and restarting. Here the bench varies the status it returns in cycle 33 and checks whether cycle 1 or the done pulse follows.

// File: rtl/irq_ser_pkg.sv
package irq_ser_pkg;

  localparam int SLOT_W = 6;

  localparam logic [SLOT_W-1:0] SL_IDLE = 6'd0;
  localparam logic [SLOT_W-1:0] SL_TYPE = 6'd1;
  localparam logic [SLOT_W-1:0] SL_ARB0 = 6'd2;
  localparam logic [SLOT_W-1:0] SL_ARB3 = 6'd5;
  localparam logic [SLOT_W-1:0] SL_SUM0 = 6'd6;
  localparam logic [SLOT_W-1:0] SL_SUM1 = 6'd16;
  localparam logic [SLOT_W-1:0] SL_CSUM = 6'd17;
  localparam logic [SLOT_W-1:0] SL_POST = 6'd18;
  localparam logic [SLOT_W-1:0] SL_REL0 = 6'd19;
  localparam logic [SLOT_W-1:0] SL_ACK  = 6'd33;
  localparam logic [SLOT_W-1:0] SL_END  = 6'd34;

  localparam logic [1:0] PAIR_REL  = 2'b11;
  localparam logic [1:0] PAIR_POST = 2'b00;
  localparam logic [1:0] TYPE_NORM = 2'b01;
  localparam logic [1:0] TYPE_EOI  = 2'b11;
  localparam logic [1:0] ST_ACCEPT = 2'b10;

  typedef struct packed {
    logic       eoi;
    logic [3:0] arb_id;
    logic       dst_mode;
    logic [2:0] dlv_mode;
    logic       level;
    logic       trig;
    logic [7:0] vec;
    logic [7:0] dst;
  } irq_msg_t;

  // pair carried in the checksum-covered window (slots 6..16)
  function automatic logic [1:0] field_pair(irq_msg_t m, logic [SLOT_W-1:0] slot);
    logic [21:0] pl;
    int k;
    pl = {m.dst_mode, m.dlv_mode, m.level, m.trig, m.vec, m.dst};
    k  = int'(slot) - int'(SL_SUM0);
    if (k < 0 || k > 10) return 2'b00;
    return {pl[21-2*k], pl[20-2*k]};
  endfunction

endpackage

// File: rtl/irq_slot_seq.sv
module irq_slot_seq
  import irq_ser_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              restart_i,
  output logic [SLOT_W-1:0] slot_o
);

  logic [SLOT_W-1:0] slot_q, slot_d;

  always_comb begin
    slot_d = slot_q;
    if (slot_q == SL_IDLE) begin
      if (start_i) slot_d = SL_TYPE;
    end else if (slot_q == SL_END) begin
      slot_d = restart_i ? SL_TYPE : SL_IDLE;
    end else begin
      slot_d = slot_q + 6'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= SL_IDLE;
    else         slot_q <= slot_d;
  end

  assign slot_o = slot_q;

  a_r2_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q != SL_IDLE && slot_q != SL_END) |=> slot_q == $past(slot_q) + 6'd1);

  a_r9_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q == SL_END && restart_i) |=> slot_q == SL_TYPE);

  a_r2_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= SL_END);

endmodule

// File: rtl/irq_frame_enc.sv
module irq_frame_enc
  import irq_ser_pkg::*;
(
  input  logic [SLOT_W-1:0] slot_i,
  input  irq_msg_t          msg_i,
  output logic [1:0]        pair_o
);

  logic [1:0] csum;

  always_comb begin
    csum = 2'b00;
    for (int s = int'(SL_SUM0); s <= int'(SL_SUM1); s++)
      csum = csum + field_pair(msg_i, SLOT_W'(s));
  end

  always_comb begin
    pair_o = PAIR_REL;
    if (slot_i == SL_TYPE)
      pair_o = msg_i.eoi ? TYPE_EOI : TYPE_NORM;
    else if (slot_i >= SL_ARB0 && slot_i <= SL_ARB3)
      pair_o = {msg_i.arb_id[2'(SL_ARB3 - slot_i)], 1'b0};
    else if (slot_i >= SL_SUM0 && slot_i <= SL_SUM1)
      pair_o = field_pair(msg_i, slot_i);
    else if (slot_i == SL_CSUM)
      pair_o = csum;
    else if (slot_i == SL_POST)
      pair_o = PAIR_POST;
  end

endmodule

// File: rtl/irq_retry_ctl.sv
module irq_retry_ctl
  import irq_ser_pkg::*;
#(
  parameter int MAX_RETRY = 3,
  parameter int RETRY_W   = $clog2(MAX_RETRY + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [SLOT_W-1:0]  slot_i,
  input  logic [1:0]         bus_i,
  output logic               restart_o,
  output logic               done_o,
  output logic               error_o,
  output logic [RETRY_W-1:0] retry_cnt_o
);

  localparam logic [RETRY_W-1:0] RETRY_MAX = RETRY_W'(MAX_RETRY);

  logic               ack_q, done_q, err_q;
  logic [RETRY_W-1:0] retry_q;
  logic               at_end, budget_left;

  assign at_end      = (slot_i == SL_END);
  assign budget_left = (retry_q < RETRY_MAX);
  assign restart_o   = at_end && !ack_q && budget_left;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      retry_q <= '0;
    end else begin
      if (slot_i == SL_ACK) ack_q <= (bus_i == ST_ACCEPT);
      done_q <= at_end && !restart_o;
      err_q  <= at_end && !ack_q && !budget_left;
      if (start_i)        retry_q <= '0;
      else if (restart_o) retry_q <= retry_q + 1'b1;
    end
  end

  assign done_o      = done_q;
  assign error_o     = err_q;
  assign retry_cnt_o = retry_q;

  a_r8_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  a_r10_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> done_q);

  a_r10_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_q <= RETRY_MAX);

  a_r9_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> retry_q == $past(retry_q) + 1'b1);

  a_r12_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> retry_q == '0);

  a_r8_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i == SL_ACK && bus_i == ST_ACCEPT) |=> ##1 (done_q && !err_q));

endmodule

// File: rtl/irq_lp_msg_tx.sv
module irq_lp_msg_tx
  import irq_ser_pkg::*;
#(
  parameter int MAX_RETRY = 3,
  parameter int RETRY_W   = $clog2(MAX_RETRY + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               eoi_i,
  input  logic [3:0]         arb_id_i,
  input  logic               dst_mode_i,
  input  logic [2:0]         dlv_mode_i,
  input  logic               level_i,
  input  logic               trig_i,
  input  logic [7:0]         vector_i,
  input  logic [7:0]         dest_i,
  input  logic [1:0]         bus_i,
  output logic [1:0]         bus_o,
  output logic               done_o,
  output logic               error_o,
  output logic [RETRY_W-1:0] retry_cnt_o
);

  logic [SLOT_W-1:0] slot;
  logic              start, restart;
  irq_msg_t          msg_q;
  logic [1:0]        pair;

  assign start = req_i && (slot == SL_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_q <= '0;
    end else if (start) begin
      msg_q <= '{eoi: eoi_i, arb_id: arb_id_i, dst_mode: dst_mode_i,
                 dlv_mode: dlv_mode_i, level: level_i, trig: trig_i,
                 vec: vector_i, dst: dest_i};
    end
  end

  irq_slot_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .restart_i(restart),
    .slot_o   (slot)
  );

  irq_frame_enc u_enc (
    .slot_i(slot),
    .msg_i (msg_q),
    .pair_o(pair)
  );

  irq_retry_ctl #(
    .MAX_RETRY(MAX_RETRY),
    .RETRY_W  (RETRY_W)
  ) u_retry (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .slot_i     (slot),
    .bus_i      (bus_i),
    .restart_o  (restart),
    .done_o     (done_o),
    .error_o    (error_o),
    .retry_cnt_o(retry_cnt_o)
  );

  assign bus_o = (slot == SL_IDLE) ? PAIR_REL : pair;

  a_r1_idle_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot == SL_IDLE) |-> bus_o == PAIR_REL);

  a_r7_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot >= SL_REL0) |-> bus_o == PAIR_REL);

  a_r7_postamble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot == SL_POST) |-> bus_o == PAIR_POST);

  a_r4_arb_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot >= SL_ARB0 && slot <= SL_ARB3) |-> !bus_o[0]);

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot != SL_IDLE) |=> $stable(msg_q));

  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> slot == SL_IDLE);

endmodule

// File: tb/irq_lp_msg_tx_test.sv
`timescale 1ns/1ps
module irq_lp_msg_tx_test;

  localparam int MAX = 2;
  localparam int RW  = $clog2(MAX + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic          eoi_i = 1'b0;
  logic [3:0]    arb_id_i = '0;
  logic          dst_mode_i = 1'b0;
  logic [2:0]    dlv_mode_i = '0;
  logic          level_i = 1'b0;
  logic          trig_i = 1'b0;
  logic [7:0]    vector_i = '0;
  logic [7:0]    dest_i = '0;
  logic [1:0]    bus_i = 2'b11;
  logic [1:0]    bus_o;
  logic          done_o, error_o;
  logic [RW-1:0] retry_cnt_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;

  irq_lp_msg_tx #(.MAX_RETRY(MAX)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .eoi_i(eoi_i),
    .arb_id_i(arb_id_i), .dst_mode_i(dst_mode_i), .dlv_mode_i(dlv_mode_i),
    .level_i(level_i), .trig_i(trig_i), .vector_i(vector_i), .dest_i(dest_i),
    .bus_i(bus_i), .bus_o(bus_o), .done_o(done_o), .error_o(error_o),
    .retry_cnt_o(retry_cnt_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // m = {eoi, arb[3:0], dm, dlv[2:0], lvl, trg, vec[7:0], dst[7:0]}
  task automatic set_fields(input logic [26:0] m);
    eoi_i = m[26]; arb_id_i = m[25:22]; dst_mode_i = m[21];
    dlv_mode_i = m[20:18]; level_i = m[17]; trig_i = m[16];
    vector_i = m[15:8]; dest_i = m[7:0];
  endtask

  function automatic logic [1:0] exp_pair(input logic [26:0] m, input int s);
    logic [21:0] pl;
    int sum;
    pl = m[21:0];
    if (s == 1) return m[26] ? 2'd3 : 2'd1;
    if (s >= 2 && s <= 5) return {m[25 - (s - 2)], 1'b0};
    if (s >= 6 && s <= 16) return 2'((pl >> (2 * (16 - s))) & 22'd3);
    if (s == 17) begin
      sum = 0;
      for (int k = 6; k <= 16; k++) sum += int'((pl >> (2 * (16 - k))) & 22'd3);
      return 2'(sum % 4);
    end
    if (s == 18) return 2'd0;
    return 2'd3;
  endfunction

  function automatic string slot_tag(input int s);
    if (s == 1) return "R3";
    if (s <= 5) return "R4";
    if (s <= 16) return "R5";
    if (s == 17) return "R6";
    return "R7";
  endfunction

  // called at a negedge with the block idle; returns at the negedge of the done clock
  task automatic xfer(input logic [26:0] m, input int naks, input logic [1:0] nak_val,
                      input bit poke);
    int  last_att;
    bit  give_up;
    last_att = (naks > MAX) ? MAX : naks;
    give_up  = (naks > MAX);
    set_fields(m);
    req_i = 1'b1;
    for (int a = 0; a <= last_att; a++) begin
      for (int s = 1; s <= 34; s++) begin
        @(negedge clk_i);
        if (a == 0 && s == 1) req_i = 1'b0;
        if (s == 1) begin
          chk("R9 retry count at attempt start", 32'(retry_cnt_o), 32'(a));
          chk("R12 done low in new frame", 32'(done_o), 32'd0);
        end
        if (poke && a == 0 && s == 9) begin
          set_fields(~m);
          req_i = 1'b1;
        end
        if (poke && a == 0 && s == 10) req_i = 1'b0;
        chk(slot_tag(s), 32'(bus_o), 32'(exp_pair(m, s)));
        if (s == 33) bus_i = (a < naks) ? nak_val : 2'b10;
        if (s == 34) begin
          bus_i = 2'b11;
          chk("R8 done low before end", 32'(done_o), 32'd0);
        end
      end
    end
    @(negedge clk_i);
    chk("R8 done pulse", 32'(done_o), 32'd1);
    chk("R10 error flag", 32'(error_o), 32'(give_up));
    chk("R10 final retry count", 32'(retry_cnt_o), 32'(last_att));
    chk("R1 released after frame", 32'(bus_o), 32'd3);
  endtask

  task automatic idle_gap(input int n, input int exp_retry);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      chk("R1 idle bus", 32'(bus_o), 32'd3);
      chk("R1 idle done", 32'(done_o), 32'd0);
      chk("R1 idle error", 32'(error_o), 32'd0);
      chk("R10 retry held", 32'(retry_cnt_o), 32'(exp_retry));
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [26:0] m;
    repeat (3) @(negedge clk_i);
    chk("R1 reset bus", 32'(bus_o), 32'd3);
    rst_ni = 1'b1;
    idle_gap(2, 0);

    // sweep: every vector, varied fields, back-to-back
    for (int i = 0; i < 256; i++) begin
      logic [7:0] b;
      b = 8'(i);
      m = {b[0] ^ b[5], b[3:0] ^ b[7:4], b[1], b[4:2], b[6], b[7], b, 8'(i * 37 + 11)};
      xfer(m, 0, 2'b00, 1'b0);
    end
    idle_gap(3, 0);

    // R9: one failed attempt per non-accept status
    xfer(27'h5A5_A5A5, 1, 2'b00, 1'b0);
    xfer(27'h3C3_0FF0, 1, 2'b01, 1'b0);
    xfer(27'h7FF_FFFF, 2, 2'b11, 1'b0);
    // R10: resends exhausted
    xfer(27'h123_4567, MAX + 1, 2'b11, 1'b0);
    idle_gap(3, MAX);
    xfer(27'h0AB_CDEF, MAX + 1, 2'b00, 1'b0);
    // R12: count clears on next message
    xfer(27'h000_0000, 0, 2'b00, 1'b0);
    // R11: late request and field change ignored, including across a resend
    xfer(27'h2D2_1E87, 0, 2'b00, 1'b1);
    xfer(27'h4B1_96C3, 1, 2'b01, 1'b1);
    idle_gap(2, 1);
    finish_run();
  end

endmodule